// File: doc/BRIEF.md
# Dual-Mode DAC Input Interface

This block is the digital front end of a 14-bit voltage-mode DAC. A sample word arrives on one shared set of pins, either as a parallel word or as a three-wire serial frame. In parallel form it is strobed by chip-select and write. In serial form it arrives as frame sync, serial clock and data. The word lands in an input latch. A separate load strobe then moves it into the DAC latch, so a new sample can be staged while the old one is still being converted.

The DAC latch drives the switch controls of the converter. Its top three bits are expanded into seven segment switch enables as a thermometer code. The lower eleven bits go straight to the ladder switches. All external strobes are brought into the system clock domain through a two-flop synchroniser, and every edge is detected in that domain.

Top module: `dac_front_end`

## Requirements
- R1: While `rst_n` is low at a clock edge, both latches clear to zero, so `seg_sw` is 0000000 and `ladder` is all zeros.
- R2: In parallel mode (`ser_mode`=0), while `cs_n` and `wr_n` are both low the word on `din[13:0]` is written into the input latch (bit 13 MSB). The last value written stays after `wr_n` returns high.
- R3: In parallel mode, a write strobe on `wr_n` while `cs_n` is high leaves the input latch unchanged.
- R4: The DAC latch takes the input latch value only on a falling edge of `ldac_n`, and holds its value at all other times.
- R5: In serial mode (`ser_mode`=1), the pins are used as follows: `din[13]` is data, `din[12]` is serial clock, `din[11]` is format and `din[10]` is justify. A frame starts on a falling edge of `wr_n`, and a bit is taken on each falling `din[12]` edge while `wr_n` is low. With format 1 (MSB first) and justify 1 (right), the word is bits 3 to 16 of the 16-bit frame.
- R6: With justify 0 (left), the word is the first 14 bits of the 16-bit frame, and the last two bits are ignored.
- R7: With format 0, the first valid bit of the frame is the LSB.
- R8: If `wr_n` returns high before the 16th bit of a frame, the partial word is dropped and the input latch keeps its old value.
- R9: Serial clock edges after the 16th bit of a frame, up to the next falling edge of `wr_n`, do not change the input latch.
- R10: A 3-bit segment value n (DAC latch bits 13..11) asserts `seg_sw[n-1:0]` and clears the remaining segment bits, so 7 asserts all seven.
- R11: `ladder` equals DAC latch bits 10..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_mode | input | 1 | Static mode select: 1 selects serial loading |
| cs_n | input | 1 | Parallel chip select, active low |
| wr_n | input | 1 | Parallel write strobe; frame sync in serial mode |
| ldac_n | input | 1 | Load strobe; a falling edge copies the input latch to the DAC latch |
| din | input | 14 | Parallel data; in serial mode bits 13..10 are data, clock, format and justify |
| seg_sw | output | 7 | Thermometer-coded segment switch enables |
| ladder | output | 11 | Ladder switch code |

## Verification
A wrong input latch stays hidden until the next falling edge of `ldac_n`. It then shows on both output buses about four clock cycles after the strobe. For that reason every loading scenario ends with a load pulse and a port comparison. A serial path that miscounts bits or misplaces the justify window gives a word that is shifted or bit-reversed against the frame, so each format and justify pairing is sent with an asymmetric word. A segment decode fault is visible as soon as the DAC latch settles, and it is swept over all eight segment values.

// File: rtl/dacif_pkg.sv
// Package: shared sizes for the DAC input interface.
// Assumes a frame at least as long as the data word.
package dacif_pkg;
    localparam int WORD_W    = 14;
    localparam int SEG_BITS  = 3;
    localparam int FRAME_LEN = 16;
endpackage

// File: rtl/dacif_sync.sv
// Module: dacif_sync
// Two-flop synchroniser for a bundle of asynchronous inputs. All bits share
// the same latency, so data and its strobes stay aligned.
// Assumes each input level is held for at least two clock cycles.
module dacif_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/dacif_serial_rx.sv
// Module: dacif_serial_rx
// Collects one serial frame of FRAME_LEN bits and presents the selected
// WORD_W-bit window, in the selected bit order, with a one-cycle valid.
// Assumes synchronised inputs and FRAME_LEN >= WORD_W.
module dacif_serial_rx #(
    parameter int WORD_W    = 14,
    parameter int FRAME_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sync_n,
    input  logic              sync_fall,
    input  logic              sclk_fall,
    input  logic              sdata,
    input  logic              msb_first,
    input  logic              right_just,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] nxt;
    logic [CNT_W-1:0]     cnt;
    logic                 active;
    logic                 take;
    logic [WORD_W-1:0]    recv;
    logic [WORD_W-1:0]    rev;

    // A bit is taken on a clock fall inside an open frame
    always_comb begin
        take = en && active && !sync_n && !sync_fall && sclk_fall;
        nxt  = {shreg[FRAME_LEN-2:0], sdata};
    end

    // Frame state: open on sync fall, close on sync rise or full frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (sync_fall) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (sync_n) begin
            active <= 1'b0;
        end else if (take) begin
            shreg <= nxt;
            if (cnt == CNT_W'(FRAME_LEN - 1)) begin
                cnt    <= '0;
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Window select: right takes the newest bits, left the oldest
    always_comb begin
        recv = right_just ? nxt[WORD_W-1:0] : nxt[FRAME_LEN-1 -: WORD_W];
    end

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_rev
            assign rev[i] = recv[WORD_W-1-i];
        end
    endgenerate

    // Completed word and its valid pulse
    always_comb begin
        word_valid = take && (cnt == CNT_W'(FRAME_LEN - 1));
        word       = msb_first ? recv : rev;
    end

    a_r8_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |=> !active);
    a_r9_frame_closes: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !active);
endmodule

// File: rtl/dacif_seg_decode.sv
// Module: dacif_seg_decode
// Expands an n-bit segment value into 2**n-1 thermometer switch enables:
// value v drives the lowest v outputs high.
module dacif_seg_decode #(
    parameter int SEG_BITS = 3
) (
    input  logic [SEG_BITS-1:0]         code,
    output logic [(1<<SEG_BITS)-2:0]    sw
);
    localparam int SEG_N = (1 << SEG_BITS) - 1;

    generate
        for (genvar i = 0; i < SEG_N; i++) begin : g_seg
            // One comparator for each switch
            assign sw[i] = (code > SEG_BITS'(i));
        end
    endgenerate
endmodule

// File: rtl/dac_front_end.sv
// Module: dac_front_end
// Dual-mode input interface for a 14-bit DAC. It takes parallel or serial
// writes into an input latch, loads the DAC latch on a falling load strobe,
// and drives the segment and ladder switch codes.
// Assumes ser_mode is static and all strobes are slow against clk.
module dac_front_end #(
    parameter int WORD_W    = dacif_pkg::WORD_W,
    parameter int SEG_BITS  = dacif_pkg::SEG_BITS,
    parameter int FRAME_LEN = dacif_pkg::FRAME_LEN
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ser_mode,
    input  logic                           cs_n,
    input  logic                           wr_n,
    input  logic                           ldac_n,
    input  logic [WORD_W-1:0]              din,
    output logic [(1<<SEG_BITS)-2:0]       seg_sw,
    output logic [WORD_W-SEG_BITS-1:0]     ladder
);
    localparam int LAD_W    = WORD_W - SEG_BITS;
    localparam int BUS_W    = WORD_W + 3;
    localparam int SDATA_P  = WORD_W - 1;
    localparam int SCLK_P   = WORD_W - 2;
    localparam int FMT_P    = WORD_W - 3;
    localparam int JUST_P   = WORD_W - 4;

    logic [BUS_W-1:0]  bus_s;
    logic [WORD_W-1:0] din_s;
    logic              cs_s, wr_s, ldac_s, sclk_s;
    logic              wr_q, ldac_q, sclk_q;
    logic              sync_fall, sclk_fall, ldac_fall, par_wr;
    logic              rx_valid;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] in_latch;
    logic [WORD_W-1:0] dac_latch;

    dacif_sync #(
        .W       (BUS_W),
        .RST_VAL ({3'b111, {WORD_W{1'b0}}})
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ldac_n, wr_n, cs_n, din}),
        .d_sync  (bus_s)
    );

    // Unpack the synchronised bundle
    always_comb begin
        {ldac_s, wr_s, cs_s, din_s} = bus_s;
        sclk_s = din_s[SCLK_P];
    end

    // Previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b1;
            ldac_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            wr_q   <= wr_s;
            ldac_q <= ldac_s;
            sclk_q <= sclk_s;
        end
    end

    // Edge and strobe decode
    always_comb begin
        sync_fall = wr_q && !wr_s;
        sclk_fall = sclk_q && !sclk_s;
        ldac_fall = ldac_q && !ldac_s;
        par_wr    = !ser_mode && !cs_s && !wr_s;
    end

    dacif_serial_rx #(
        .WORD_W    (WORD_W),
        .FRAME_LEN (FRAME_LEN)
    ) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ser_mode),
        .sync_n     (wr_s),
        .sync_fall  (sync_fall),
        .sclk_fall  (sclk_fall),
        .sdata      (din_s[SDATA_P]),
        .msb_first  (din_s[FMT_P]),
        .right_just (din_s[JUST_P]),
        .word_valid (rx_valid),
        .word       (rx_word)
    );

    // Input latch: parallel level write or completed serial word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_latch <= '0;
        end else if (par_wr) begin
            in_latch <= din_s;
        end else if (ser_mode && rx_valid) begin
            in_latch <= rx_word;
        end
    end

    // DAC latch: loads on the falling load strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_latch <= '0;
        end else if (ldac_fall) begin
            dac_latch <= in_latch;
        end
    end

    dacif_seg_decode #(
        .SEG_BITS (SEG_BITS)
    ) i_seg (
        .code (dac_latch[WORD_W-1 -: SEG_BITS]),
        .sw   (seg_sw)
    );

    assign ladder = dac_latch[LAD_W-1:0];

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (in_latch == '0) && (dac_latch == '0));
    a_r2_par_capture: assert property (@(posedge clk) disable iff (!rst_n)
        par_wr |=> in_latch == $past(din_s));
    a_r3_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && cs_s) |=> $stable(in_latch));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_fall |=> $stable(dac_latch));
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        ldac_fall |=> dac_latch == $past(in_latch));
    a_r10_seg_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_sw) == int'(dac_latch[WORD_W-1 -: SEG_BITS]));
    a_r10_seg_contig: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_sw + 1'b1) & seg_sw) == '0);
endmodule

// File: tb/test_dac_front_end.sv
module test_dac_front_end;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ldac_n = 1'b1;
    logic [13:0] din = '0;
    logic [6:0]  seg_sw;
    logic [10:0] ladder;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dac_front_end i_dac_front_end (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .cs_n(cs_n),
        .wr_n(wr_n), .ldac_n(ldac_n), .din(din), .seg_sw(seg_sw),
        .ladder(ladder)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [13:0] rev14(input logic [13:0] w);
        logic [13:0] r;
        for (int i = 0; i < 14; i++) r[i] = w[13-i];
        return r;
    endfunction

    // Compare outputs with the switch codes expected for word w
    task automatic expect_word(input logic [13:0] w, input string tag);
        logic [6:0] seg_e;
        for (int i = 0; i < 7; i++) seg_e[i] = (i < int'(w[13:11]));
        n_run++;
        if (seg_sw !== seg_e || ladder !== w[10:0]) begin
            n_fail++;
            $display("FAIL %s: seg=%b ladder=%h expected seg=%b ladder=%h",
                     tag, seg_sw, ladder, seg_e, w[10:0]);
        end
    endtask

    task automatic par_write(input logic [13:0] w, input logic cs);
        din = w; cs_n = cs; wr_n = 1'b0;
        step(4);
        wr_n = 1'b1;
        step(4);
        cs_n = 1'b1;
        step(2);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        step(4);
        ldac_n = 1'b1;
        step(4);
    endtask

    // Send bits[n-1] first down to bits[0]; abort closes sync early
    task automatic ser_frame(input logic [23:0] bits, input int n,
                             input logic fmt, input logic just);
        din = '0; din[11] = fmt; din[10] = just; din[12] = 1'b1;
        wr_n = 1'b0;
        step(4);
        for (int i = n - 1; i >= 0; i--) begin
            din[13] = bits[i]; din[12] = 1'b1;
            step(3);
            din[12] = 1'b0;
            step(3);
        end
        din[12] = 1'b1;
        step(3);
        wr_n = 1'b1;
        step(4);
        din[12] = 1'b0;
        step(3);
    endtask

    task automatic t_reset();
        step(3);
        rst_n = 1'b1;
        step(2);
        expect_word(14'h0000, "R1 reset");
    endtask

    task automatic t_parallel();
        par_write(14'h2A5C, 1'b0);
        expect_word(14'h0000, "R4 no load before strobe");
        pulse_ldac();
        expect_word(14'h2A5C, "R2 parallel write");
        par_write(14'h1337, 1'b1);
        pulse_ldac();
        expect_word(14'h2A5C, "R3 cs high ignored");
        par_write(14'h0F0F, 1'b0);
        step(10);
        expect_word(14'h2A5C, "R4 hold without strobe");
        pulse_ldac();
        expect_word(14'h0F0F, "R4 load on fall");
    endtask

    task automatic t_segments();
        for (int n = 0; n < 8; n++) begin
            par_write({n[2:0], 11'h5A3 ^ 11'(n * 37)}, 1'b0);
            pulse_ldac();
            expect_word({n[2:0], 11'h5A3 ^ 11'(n * 37)}, "R10 R11 segment sweep");
        end
    endtask

    task automatic t_serial();
        logic [13:0] w;
        ser_mode = 1'b1;
        step(6);
        w = 14'h3A61;
        ser_frame({8'h0, 2'b10, w}, 16, 1'b1, 1'b1);
        pulse_ldac();
        expect_word(w, "R5 msb first right");
        w = 14'h0C93;
        ser_frame({8'h0, w, 2'b11}, 16, 1'b1, 1'b0);
        pulse_ldac();
        expect_word(w, "R6 left justify");
        w = 14'h2B07;
        ser_frame({8'h0, 2'b01, rev14(w)}, 16, 1'b0, 1'b1);
        pulse_ldac();
        expect_word(w, "R7 lsb first right");
        w = 14'h1E4D;
        ser_frame({8'h0, rev14(w), 2'b00}, 16, 1'b0, 1'b0);
        pulse_ldac();
        expect_word(w, "R7 lsb first left");
        ser_frame({8'h0, 2'b11, 14'h3FFF}, 10, 1'b1, 1'b1);
        pulse_ldac();
        expect_word(w, "R8 partial frame dropped");
        w = 14'h05AA;
        ser_frame({6'h0, 2'b00, w, 2'b11}, 18, 1'b1, 1'b1);
        pulse_ldac();
        expect_word(w, "R9 extra clocks ignored");
        ser_mode = 1'b0;
        step(6);
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_segments();
        t_serial();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule